// File: doc/BRIEF.md
# Tear-Free Byte Read Latch for a Position Counter

The block lets an 8-bit data bus read a 16-bit running counter in two byte accesses without seeing a torn value. A snapshot register follows the counter on every rising clock edge. A hold flag freezes the snapshot while a two-byte read is under way, and the counter keeps running the whole time. The hold is controlled by the bus read strobe (`oe_ni`, active low) and the byte select (`sel_i`). Both are sampled on the falling clock edge, so they must be synchronous to the clock.

A read starts with the strobe low and the select low, which returns the high byte. The hold engages at that falling edge. The select then goes high and the low byte comes out of the same frozen snapshot. Raising the strobe releases the hold. When software only needs 8 bits, it keeps the select high all the time. The hold then never engages and the low byte always tracks the counter.

The pad is modelled as a data bus plus an active-high drive enable. The drive enable is the inverse of the strobe.

Top module: `pos_read_latch`

## Requirements
- R1: On a rising clock edge with the hold flag clear, the snapshot loads the value `cnt_i` had at that edge.
- R2: On a rising clock edge with the hold flag set, the snapshot keeps its value while `cnt_i` changes.
- R3: A falling edge that samples `oe_ni` low and `sel_i` low sets the hold flag.
- R4: A falling edge that samples `oe_ni` low and `sel_i` high records the first release condition but leaves the hold set. The low byte read that follows comes from the same snapshot as the high byte.
- R5: A falling edge that samples `oe_ni` high clears the hold flag. This also applies before the first condition has been recorded, which abandons the read.
- R6: `data_o` carries snapshot bits [15:8] when `sel_i` is 0 and bits [7:0] when `sel_i` is 1. `drive_en_o` equals the inverse of `oe_ni`.
- R7: With `sel_i` held at 1, the hold never engages, whatever `oe_ni` does, and the low byte tracks the counter one edge late.
- R8: While `rst_ni` is low, the snapshot is zero and the hold is clear, so both bytes read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; rising edge loads the snapshot, falling edge samples the bus controls |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 16 | Running counter value |
| oe_ni | input | 1 | Read strobe, active low |
| sel_i | input | 1 | Byte select: 0 = high byte, 1 = low byte |
| data_o | output | 8 | Selected snapshot byte |
| drive_en_o | output | 1 | Bus drive enable, active high |

## Verification
The hardest case to reach is a counter carry across the byte boundary that lands exactly between the high-byte and low-byte accesses of one read. Only a correct hold turns that case into a coherent pair. The stimulus sets the counter to 0x12FF, starts a read, and steps the counter to 0x1300 and 0x1301 while the low byte is fetched. It expects 0x12 and then 0xFF. An abandoned read is also driven: the strobe rises before the select does, and the counter must again be tracked on the next edge. A behavioural model of both clock edges is compared with the outputs on every cycle.

// File: rtl/pos_read_pkg.sv
package pos_read_pkg;
  typedef enum logic [1:0] {
    HOLD_OFF = 2'd0,
    HOLD_HI  = 2'd1,
    HOLD_LO  = 2'd2
  } hold_state_e;
endpackage

// File: rtl/pos_hold_ctrl.sv
module pos_hold_ctrl
  import pos_read_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_ni,
  input  logic sel_i,
  output logic hold_o
);
  hold_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (oe_ni)       state_d = HOLD_OFF;  // release, or abandon
    else if (!sel_i) state_d = HOLD_HI;
    else if (state_q != HOLD_OFF) state_d = HOLD_LO;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= HOLD_OFF;
    else         state_q <= state_d;
  end

  assign hold_o = (state_q != HOLD_OFF);

  // R3
  hold_set_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!oe_ni && !sel_i) |=> hold_o);
  // R4
  hold_keep_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (hold_o && !oe_ni && sel_i) |=> (hold_o && state_q == HOLD_LO));
  // R5
  hold_release_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    oe_ni |=> !hold_o);
  // R7
  single_byte_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (sel_i && !hold_o) |=> !hold_o);
endmodule

// File: rtl/pos_snapshot.sv
module pos_snapshot #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] snap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     snap_o <= '0;
    else if (!hold_i) snap_o <= cnt_i;
  end

  // R1
  snap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i |=> (snap_o == $past(cnt_i)));
  // R2
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(snap_o));
endmodule

// File: rtl/pos_byte_mux.sv
module pos_byte_mux #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input  logic [CNT_W-1:0] snap_i,
  input  logic             sel_i,
  input  logic             oe_ni,
  output logic [BUS_W-1:0] data_o,
  output logic             drive_en_o
);
  localparam int HI_W = CNT_W - BUS_W;

  logic [BUS_W-1:0] hi_byte;
  logic [BUS_W-1:0] lo_byte;

  assign lo_byte = snap_i[BUS_W-1:0];

  generate
    if (HI_W == BUS_W) begin : g_full_hi
      assign hi_byte = snap_i[CNT_W-1:BUS_W];
    end else begin : g_short_hi
      assign hi_byte = {{(BUS_W-HI_W){1'b0}}, snap_i[CNT_W-1:BUS_W]};
    end
  endgenerate

  assign data_o     = sel_i ? lo_byte : hi_byte;
  assign drive_en_o = ~oe_ni;

  // R6
  always_comb begin
    sel_route_chk: assert (sel_i ? (data_o == snap_i[BUS_W-1:0])
                                 : (data_o[HI_W-1:0] == snap_i[CNT_W-1:BUS_W]));
  end
endmodule

// File: rtl/pos_read_latch.sv
module pos_read_latch #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             oe_ni,
  input  logic             sel_i,
  output logic [BUS_W-1:0] data_o,
  output logic             drive_en_o
);
  logic             hold;
  logic [CNT_W-1:0] snap;

  pos_hold_ctrl i_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .oe_ni (oe_ni),
    .sel_i (sel_i),
    .hold_o(hold)
  );

  pos_snapshot #(.CNT_W(CNT_W)) i_snap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hold_i(hold),
    .cnt_i (cnt_i),
    .snap_o(snap)
  );

  pos_byte_mux #(.CNT_W(CNT_W), .BUS_W(BUS_W)) i_mux (
    .snap_i    (snap),
    .sel_i     (sel_i),
    .oe_ni     (oe_ni),
    .data_o    (data_o),
    .drive_en_o(drive_en_o)
  );
endmodule

// File: tb/test_pos_read_latch.sv
module test_pos_read_latch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = 16'h0;
  logic        oe_n = 1'b1;
  logic        sel = 1'b0;
  logic [7:0]  data;
  logic        drive_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // behavioural reference
  int m_snap = 0;
  bit m_hold = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pos_read_latch i_pos_read_latch (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cnt_i     (cnt),
    .oe_ni     (oe_n),
    .sel_i     (sel),
    .data_o    (data),
    .drive_en_o(drive_en)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_snap = 0;
    else if (!m_hold) m_snap = int'(cnt);
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) m_hold = 1'b0;
    else if (oe_n) m_hold = 1'b0;
    else if (!sel) m_hold = 1'b1;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic compare_model(input string req);
    logic [7:0] exp_d;
    exp_d = sel ? m_snap[7:0] : m_snap[15:8];
    check({req, " data"}, data, exp_d);
    check("R6 drive_en", {7'b0, drive_en}, {7'b0, ~oe_n});
  endtask

  // drive after rising edge, check before falling edge
  task automatic step(input logic [15:0] c, input logic o, input logic s, input string req);
    @(posedge clk);
    #2;
    cnt = c; oe_n = o; sel = s;
    #1;
    compare_model(req);
  endtask

  initial begin
    sel = 1'b0; cnt = 16'hABCD;
    repeat (3) @(posedge clk);
    #3;
    check("R8 reset hi", data, 8'h00);
    sel = 1'b1;
    #1;
    check("R8 reset lo", data, 8'h00);
    check("R8 reset en", {7'b0, drive_en}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 tracking, several patterns, strobe idle
    for (int i = 0; i < 8; i++) step(16'h0100 * i + 16'h11 * i, 1, i % 2, "R1");

    // R2 R3 R4 carry across byte boundary during a read
    step(16'h12FF, 1, 1, "R1");
    step(16'h12FF, 1, 1, "R1");
    step(16'h1300, 0, 0, "R3");
    check("R3 hi byte", data, 8'h12);
    step(16'h1301, 0, 1, "R4");
    check("R4 lo byte coherent", data, 8'hFF);
    step(16'h1302, 0, 1, "R2");
    check("R2 frozen", data, 8'hFF);
    step(16'h1303, 1, 1, "R5");
    check("R5 en off", {7'b0, drive_en}, 8'h00);
    step(16'h1304, 1, 1, "R5");
    check("R5 resumed", data, 8'h03);

    // R5 abandoned read: strobe rises before select
    step(16'h2200, 0, 0, "R3");
    step(16'h3300, 0, 0, "R2");
    check("R2 held hi", data, 8'h13);
    step(16'h4400, 1, 0, "R5");
    step(16'h5500, 1, 0, "R5");
    check("R5 abandon tracks", data, 8'h44);

    // R7 single-byte mode
    for (int i = 0; i < 10; i++) step(16'h7000 + 16'(i * 37), (i % 3) == 0, 1, "R7");
    step(16'h70AA, 0, 1, "R7");
    step(16'h70BB, 0, 1, "R7");
    check("R7 lo tracks", data, 8'hAA);

    // mixed sequence
    for (int i = 0; i < 40; i++)
      step(16'(i * 613), (i % 5) == 4, (i % 7) > 2, "R6");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule